// File: doc/BRIEF.md
# Address Translation Sequencer

This block runs one address translation at a time through a fixed chain of steps and ends it with a single result. The result is either a real address with a rights vector (read, write, execute) or an exception with its syndrome values. A request carries an effective address, an access kind (load, store or fetch) and a privilege bit. The block also samples the instruction and data translation enables at that moment. Sixteen segment descriptors are held in a small register file that is written through a dedicated port.

The block consults two neighbours through request/response ports: a block-range matcher and a page-table walker. The chain is ordered as follows: untranslated mode, block match, segment descriptor, direct-store segment, segment no-execute, page-table search, and finally key-based page protection. Each way out of the chain writes its own syndrome word. All result outputs are registered and stay stable until the next result.

Top module: `xlate_seq`

## Requirements
- R1: A fetch with `itrans_en` low, or a load/store with `dtrans_en` low, completes with `raddr` equal to the effective address and `rights` = 3'b111. Neither neighbour is requested. Access kind encoding is 0 load, 1 store, 2 fetch. Rights bits are [0] read, [1] write, [2] execute.
- R2: Every translated request is first sent to the block matcher. A hit that holds the needed right (read for load, write for store, execute for fetch) completes with the matcher's address and rights, and the walker is never requested.
- R3: A block hit that lacks the needed right faults without a walk. A fetch gets `exc_kind`=1 and `icode`=0x08000000. A data access gets `exc_kind`=2, `dar`=EA, and `dsisr`=0x0A000000 for a store or 0x08000000 for a load.
- R4: After a block miss, the segment descriptor is selected by EA[31:28]. The walker is requested with `pw_vsid` = descriptor[23:0] and `pw_page` = EA[27:12].
- R5: A fetch from a segment with descriptor bit 31 (direct-store) clear and bit 28 (no-execute) set faults with `exc_kind`=1 and `icode`=0x10000000, and no walk.
- R6: In a direct-store segment whose bits 28:20 equal 0x07F, any access completes with `raddr` = {descriptor[3:0], EA[27:0]} and `rights`=3'b111. In any other direct-store segment, a fetch faults with `icode`=0x10000000.
- R7: For a load or store in a direct-store segment that is not 0x07F, a load is granted when the key is 0 and a store is granted when the key is 1. A grant gives `raddr`=EA and `rights`=3'b011. Otherwise the access faults with the R3 data syndromes. No walk takes place.
- R8: The key is descriptor bit 29 when `req_user` is 1 and descriptor bit 30 otherwise. With key 0, page protection values 0, 1 and 2 give read/write and 3 gives read only. With key 1, value 0 gives nothing, 1 and 3 give read only, and 2 gives read/write.
- R9: A walker hit whose rights (per R8, plus execute when bit 28 is clear) hold the needed right completes with `raddr` = {`pw_rpn`, EA[11:0]} and those rights.
- R10: A walker miss faults. A fetch gets `icode`=0x40000000. A data access gets `dar`=EA and `dsisr`=0x42000000 for a store or 0x40000000 for a load.
- R11: A walker hit lacking the needed right faults with the same codes as R3.
- R12: Each accepted request yields exactly one `done` pulse. On success, `fault`=0, `exc_kind`=0 and `icode`, `dar`, `dsisr` are 0. On a fault, `raddr` and `rights` are 0, and the syndrome fields of the other exception kind are 0. All outputs hold until the next `done`.
- R13: After reset, `done`, `fault`, `raddr`, `rights`, `exc_kind` and the syndrome outputs are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (taken when req_ready) |
| req_ready | output | 1 | Sequencer idle |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 = user privilege |
| itrans_en | input | 1 | Instruction translation enable |
| dtrans_en | input | 1 | Data translation enable |
| seg_we | input | 1 | Segment descriptor write strobe |
| seg_idx | input | 4 | Descriptor index to write |
| seg_wdata | input | 32 | Descriptor value |
| bm_req | output | 1 | Block matcher request pulse |
| bm_ea | output | 32 | Address for the matcher |
| bm_fetch | output | 1 | Matcher lookup is for a fetch |
| bm_user | output | 1 | Privilege for the matcher |
| bm_rsp_valid | input | 1 | Matcher response strobe |
| bm_hit | input | 1 | Matcher found a range |
| bm_raddr | input | 32 | Real address from the matcher |
| bm_rights | input | 3 | Rights from the matcher |
| pw_req | output | 1 | Walker request pulse |
| pw_vsid | output | 24 | Virtual segment id for the walk |
| pw_page | output | 16 | Page index within the segment |
| pw_rsp_valid | input | 1 | Walker response strobe |
| pw_hit | input | 1 | Walker found an entry |
| pw_pp | input | 2 | Page protection value |
| pw_rpn | input | 20 | Real page number |
| done | output | 1 | Result pulse |
| fault | output | 1 | Result is an exception |
| raddr | output | 32 | Real address |
| rights | output | 3 | Granted rights |
| exc_kind | output | 2 | 0 none, 1 instruction, 2 data |
| icode | output | 32 | Instruction fault code |
| dar | output | 32 | Data fault address |
| dsisr | output | 32 | Data fault status word |

## Verification
The embedded properties watch, on every cycle, the structural rules of the result. A fault always names an exception kind, and a success always carries a nonzero rights vector. An instruction fault never leaves data syndrome fields set, and a data fault never leaves an instruction code set. The neighbour request strobes are single-cycle pulses, and a block hit is never followed by a walk. The ordering of the chain, the key and protection table, the direct-store rules and the exact syndrome words depend on descriptor contents and neighbour answers. Only the bench's directed and random transactions, compared against its own model of the chain, can show those.

// File: rtl/xlate_seq_pkg.sv
package xlate_seq_pkg;

  localparam int SYN_W = 32;
  localparam int RIGHTS_W = 3;
  localparam int RT_READ = 0;
  localparam int RT_WRITE = 1;
  localparam int RT_EXEC = 2;

  // descriptor field positions
  localparam int DESC_DSTORE = 31;
  localparam int DESC_KSUP = 30;
  localparam int DESC_KUSR = 29;
  localparam int DESC_NOEXEC = 28;
  localparam int DESC_BUS_HI = 28;
  localparam int DESC_BUS_LO = 20;
  localparam logic [8:0] BUS_FORCED = 9'h07F;

  typedef enum logic [1:0] {
    ACC_LOAD = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    EXK_NONE = 2'd0,
    EXK_INSTR = 2'd1,
    EXK_DATA = 2'd2
  } exk_e;

  typedef enum logic [1:0] {
    WHY_NONE = 2'd0,
    WHY_PROT = 2'd1,
    WHY_MISS = 2'd2,
    WHY_NOEXEC = 2'd3
  } why_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BLOCK = 3'd1,
    ST_SEGRD = 3'd2,
    ST_SEG = 3'd3,
    ST_WALK = 3'd4
  } st_e;

  localparam logic [SYN_W-1:0] IC_NOEXEC = 32'h1000_0000;
  localparam logic [SYN_W-1:0] IC_MISS = 32'h4000_0000;
  localparam logic [SYN_W-1:0] IC_PROT = 32'h0800_0000;
  localparam logic [SYN_W-1:0] DS_MISS_LD = 32'h4000_0000;
  localparam logic [SYN_W-1:0] DS_MISS_ST = 32'h4200_0000;
  localparam logic [SYN_W-1:0] DS_PROT_LD = 32'h0800_0000;
  localparam logic [SYN_W-1:0] DS_PROT_ST = 32'h0A00_0000;

  function automatic logic [RIGHTS_W-1:0] need_of(input logic [1:0] acc);
    logic [RIGHTS_W-1:0] m;
    m = '0;
    case (acc)
      ACC_STORE: m[RT_WRITE] = 1'b1;
      ACC_FETCH: m[RT_EXEC] = 1'b1;
      default: m[RT_READ] = 1'b1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/xlate_seg_file.sv
module xlate_seg_file #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-first synchronous RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xlate_page_rights.sv
module xlate_page_rights
  import xlate_seq_pkg::*;
(
  input  logic                user,
  input  logic                key_sup,
  input  logic                key_usr,
  input  logic                noexec,
  input  logic [1:0]          pp,
  output logic [RIGHTS_W-1:0] rights
);
  logic key;

  always_comb begin
    key = user ? key_usr : key_sup;
    rights = '0;
    case ({key, pp})
      3'b000, 3'b001, 3'b010, 3'b110: begin
        rights[RT_READ] = 1'b1;
        rights[RT_WRITE] = 1'b1;
      end
      3'b011, 3'b101, 3'b111: rights[RT_READ] = 1'b1;
      default: rights = '0;
    endcase
    rights[RT_EXEC] = !noexec;
  end

  always_comb begin
    if (key == 1'b1 && pp == 2'd0)
      AST_KEY1_PP0_NO_DATA: assert (rights[RT_READ] == 1'b0 && rights[RT_WRITE] == 1'b0); // R8
  end
endmodule

// File: rtl/xlate_dstore.sv
module xlate_dstore
  import xlate_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HI_W = 4
) (
  input  logic [ADDR_W-1:0]   ea,
  input  logic [1:0]          acc,
  input  logic                user,
  input  logic                key_sup,
  input  logic                key_usr,
  input  logic [8:0]          bus_id,
  input  logic [HI_W-1:0]     hi_bits,
  output logic                grant,
  output logic [ADDR_W-1:0]   raddr,
  output logic [RIGHTS_W-1:0] rights,
  output why_e                why
);
  logic key;

  always_comb begin
    key = user ? key_usr : key_sup;
    grant = 1'b0;
    raddr = '0;
    rights = '0;
    why = WHY_NONE;
    if (bus_id == BUS_FORCED) begin
      grant = 1'b1;
      raddr = {hi_bits, ea[ADDR_W-HI_W-1:0]};
      rights = '1;
    end else if (acc == ACC_FETCH) begin
      why = WHY_NOEXEC;
    end else if ((acc == ACC_LOAD && !key) || (acc == ACC_STORE && key)) begin
      grant = 1'b1;
      raddr = ea;
      rights[RT_READ] = 1'b1;
      rights[RT_WRITE] = 1'b1;
    end else begin
      why = WHY_PROT;
    end
  end
endmodule

// File: rtl/xlate_fault_enc.sv
module xlate_fault_enc
  import xlate_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  why_e              why,
  input  logic [1:0]        acc,
  input  logic [ADDR_W-1:0] ea,
  output exk_e              kind,
  output logic [SYN_W-1:0]  icode,
  output logic [ADDR_W-1:0] dar,
  output logic [SYN_W-1:0]  dsisr
);
  logic st;

  always_comb begin
    st = (acc == ACC_STORE);
    kind = EXK_NONE;
    icode = '0;
    dar = '0;
    dsisr = '0;
    if (why != WHY_NONE) begin
      if (acc == ACC_FETCH) begin
        kind = EXK_INSTR;
        case (why)
          WHY_PROT: icode = IC_PROT;
          WHY_MISS: icode = IC_MISS;
          default: icode = IC_NOEXEC;
        endcase
      end else begin
        kind = EXK_DATA;
        dar = ea;
        case (why)
          WHY_PROT: dsisr = st ? DS_PROT_ST : DS_PROT_LD;
          WHY_MISS: dsisr = st ? DS_MISS_ST : DS_MISS_LD;
          default: dsisr = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xlate_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEG_CNT = 16,
  parameter int VSID_W = 24,
  localparam int SEG_IDX_W = $clog2(SEG_CNT),
  localparam int PAGE_IDX_W = ADDR_W - SEG_IDX_W - PAGE_BITS,
  localparam int RPN_W = ADDR_W - PAGE_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_ea,
  input  logic [1:0]            req_acc,
  input  logic                  req_user,
  input  logic                  itrans_en,
  input  logic                  dtrans_en,
  input  logic                  seg_we,
  input  logic [SEG_IDX_W-1:0]  seg_idx,
  input  logic [31:0]           seg_wdata,
  output logic                  bm_req,
  output logic [ADDR_W-1:0]     bm_ea,
  output logic                  bm_fetch,
  output logic                  bm_user,
  input  logic                  bm_rsp_valid,
  input  logic                  bm_hit,
  input  logic [ADDR_W-1:0]     bm_raddr,
  input  logic [2:0]            bm_rights,
  output logic                  pw_req,
  output logic [VSID_W-1:0]     pw_vsid,
  output logic [PAGE_IDX_W-1:0] pw_page,
  input  logic                  pw_rsp_valid,
  input  logic                  pw_hit,
  input  logic [1:0]            pw_pp,
  input  logic [RPN_W-1:0]      pw_rpn,
  output logic                  done,
  output logic                  fault,
  output logic [ADDR_W-1:0]     raddr,
  output logic [2:0]            rights,
  output logic [1:0]            exc_kind,
  output logic [31:0]           icode,
  output logic [ADDR_W-1:0]     dar,
  output logic [31:0]           dsisr
);

  st_e state, state_d;
  logic [ADDR_W-1:0] ea_q;
  logic [1:0] acc_q;
  logic user_q;
  logic [31:0] desc;

  logic fin, bm_fire, pw_fire;
  why_e fin_why;
  logic [ADDR_W-1:0] fin_raddr;
  logic [RIGHTS_W-1:0] fin_rights;
  logic [RIGHTS_W-1:0] need;
  logic real_mode;

  logic ds_grant;
  logic [ADDR_W-1:0] ds_raddr;
  logic [RIGHTS_W-1:0] ds_rights;
  why_e ds_why;
  logic [RIGHTS_W-1:0] pg_rights;

  exk_e enc_kind;
  logic [SYN_W-1:0] enc_icode, enc_dsisr;
  logic [ADDR_W-1:0] enc_dar;

  // descriptor storage, read address is the latched segment index (R4)
  xlate_seg_file #(.DEPTH(SEG_CNT), .WIDTH(32)) u_segs (
    .clk  (clk),
    .we   (seg_we),
    .waddr(seg_idx),
    .wdata(seg_wdata),
    .raddr(ea_q[ADDR_W-1 -: SEG_IDX_W]),
    .rdata(desc)
  );

  xlate_page_rights u_rights (
    .user   (user_q),
    .key_sup(desc[DESC_KSUP]),
    .key_usr(desc[DESC_KUSR]),
    .noexec (desc[DESC_NOEXEC]),
    .pp     (pw_pp),
    .rights (pg_rights)
  );

  xlate_dstore #(.ADDR_W(ADDR_W), .HI_W(SEG_IDX_W)) u_dstore (
    .ea     (ea_q),
    .acc    (acc_q),
    .user   (user_q),
    .key_sup(desc[DESC_KSUP]),
    .key_usr(desc[DESC_KUSR]),
    .bus_id (desc[DESC_BUS_HI:DESC_BUS_LO]),
    .hi_bits(desc[SEG_IDX_W-1:0]),
    .grant  (ds_grant),
    .raddr  (ds_raddr),
    .rights (ds_rights),
    .why    (ds_why)
  );

  xlate_fault_enc #(.ADDR_W(ADDR_W)) u_enc (
    .why  (fin_why),
    .acc  (acc_q),
    .ea   (ea_q),
    .kind (enc_kind),
    .icode(enc_icode),
    .dar  (enc_dar),
    .dsisr(enc_dsisr)
  );

  assign req_ready = (state == ST_IDLE);
  assign need = need_of(acc_q);
  assign real_mode = (req_acc == ACC_FETCH) ? !itrans_en : !dtrans_en;
  assign bm_ea = ea_q;
  assign bm_fetch = (acc_q == ACC_FETCH);
  assign bm_user = user_q;

  always_comb begin
    state_d = state;
    fin = 1'b0;
    fin_why = WHY_NONE;
    fin_raddr = '0;
    fin_rights = '0;
    bm_fire = 1'b0;
    pw_fire = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (real_mode) begin
            fin = 1'b1;
            fin_raddr = req_ea;
            fin_rights = '1;
          end else begin
            bm_fire = 1'b1;
            state_d = ST_BLOCK;
          end
        end
      end
      ST_BLOCK: begin
        if (bm_rsp_valid) begin
          if (bm_hit) begin
            fin = 1'b1;
            state_d = ST_IDLE;
            if ((need & ~bm_rights) != '0) begin
              fin_why = WHY_PROT;
            end else begin
              fin_raddr = bm_raddr;
              fin_rights = bm_rights;
            end
          end else begin
            state_d = ST_SEGRD;
          end
        end
      end
      ST_SEGRD: state_d = ST_SEG;
      ST_SEG: begin
        if (desc[DESC_DSTORE]) begin
          fin = 1'b1;
          state_d = ST_IDLE;
          if (ds_grant) begin
            fin_raddr = ds_raddr;
            fin_rights = ds_rights;
          end else begin
            fin_why = ds_why;
          end
        end else if (acc_q == ACC_FETCH && desc[DESC_NOEXEC]) begin
          fin = 1'b1;
          state_d = ST_IDLE;
          fin_why = WHY_NOEXEC;
        end else begin
          pw_fire = 1'b1;
          state_d = ST_WALK;
        end
      end
      ST_WALK: begin
        if (pw_rsp_valid) begin
          fin = 1'b1;
          state_d = ST_IDLE;
          if (!pw_hit) begin
            fin_why = WHY_MISS;
          end else if ((need & ~pg_rights) != '0) begin
            fin_why = WHY_PROT;
          end else begin
            fin_raddr = {pw_rpn, ea_q[PAGE_BITS-1:0]};
            fin_rights = pg_rights;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ea_q <= '0;
      acc_q <= '0;
      user_q <= 1'b0;
      bm_req <= 1'b0;
      pw_req <= 1'b0;
      pw_vsid <= '0;
      pw_page <= '0;
      done <= 1'b0;
      fault <= 1'b0;
      raddr <= '0;
      rights <= '0;
      exc_kind <= '0;
      icode <= '0;
      dar <= '0;
      dsisr <= '0;
    end else begin
      state <= state_d;
      bm_req <= bm_fire;
      pw_req <= pw_fire;
      done <= fin;
      if (state == ST_IDLE && req_valid) begin
        ea_q <= req_ea;
        acc_q <= req_acc;
        user_q <= req_user;
      end
      if (pw_fire) begin
        pw_vsid <= desc[VSID_W-1:0];
        pw_page <= ea_q[PAGE_BITS +: PAGE_IDX_W];
      end
      if (fin) begin
        fault <= (fin_why != WHY_NONE);
        raddr <= fin_raddr;
        rights <= fin_rights;
        exc_kind <= enc_kind;
        icode <= enc_icode;
        dar <= enc_dar;
        dsisr <= enc_dsisr;
      end
    end
  end

  AST_BM_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    bm_req |=> !bm_req); // R2
  AST_NO_WALK_AFTER_BLOCK_HIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLOCK && bm_rsp_valid && bm_hit) |=> (!pw_req && state == ST_IDLE)); // R2
  AST_WALK_WAITS: assert property (@(posedge clk) disable iff (rst)
    pw_req |-> state == ST_WALK); // R4
  AST_FAULT_HAS_KIND: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (exc_kind != EXK_NONE && raddr == '0 && rights == '0)); // R12
  AST_SUCCESS_HAS_RIGHTS: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (rights != '0 && exc_kind == EXK_NONE)); // R9
  AST_INSTR_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (done && exc_kind == EXK_INSTR) |-> (dar == '0 && dsisr == '0 && icode != '0)); // R12
  AST_DATA_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (done && exc_kind == EXK_DATA) |-> (icode == '0 && dsisr != '0)); // R12

endmodule

// File: tb/xlate_seq_tb.sv
`timescale 1ns/1ps
module xlate_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_ea = '0;
  logic [1:0] req_acc = '0;
  logic req_user = 1'b0, itrans_en = 1'b0, dtrans_en = 1'b0;
  logic seg_we = 1'b0;
  logic [3:0] seg_idx = '0;
  logic [31:0] seg_wdata = '0;
  logic bm_req, bm_fetch, bm_user;
  logic [31:0] bm_ea;
  logic bm_rsp_valid = 1'b0, bm_hit = 1'b0;
  logic [31:0] bm_raddr = '0;
  logic [2:0] bm_rights = '0;
  logic pw_req;
  logic [23:0] pw_vsid;
  logic [15:0] pw_page;
  logic pw_rsp_valid = 1'b0, pw_hit = 1'b0;
  logic [1:0] pw_pp = '0;
  logic [19:0] pw_rpn = '0;
  logic done, fault;
  logic [31:0] raddr, icode, dar, dsisr;
  logic [2:0] rights;
  logic [1:0] exc_kind;

  always #2 clk = ~clk;

  xlate_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_acc(req_acc), .req_user(req_user),
    .itrans_en(itrans_en), .dtrans_en(dtrans_en),
    .seg_we(seg_we), .seg_idx(seg_idx), .seg_wdata(seg_wdata),
    .bm_req(bm_req), .bm_ea(bm_ea), .bm_fetch(bm_fetch), .bm_user(bm_user),
    .bm_rsp_valid(bm_rsp_valid), .bm_hit(bm_hit), .bm_raddr(bm_raddr), .bm_rights(bm_rights),
    .pw_req(pw_req), .pw_vsid(pw_vsid), .pw_page(pw_page),
    .pw_rsp_valid(pw_rsp_valid), .pw_hit(pw_hit), .pw_pp(pw_pp), .pw_rpn(pw_rpn),
    .done(done), .fault(fault), .raddr(raddr), .rights(rights), .exc_kind(exc_kind),
    .icode(icode), .dar(dar), .dsisr(dsisr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] seg_m [16];

  // neighbour answers for the current transaction
  logic r_bh;
  logic [31:0] r_braddr;
  logic [2:0] r_brights;
  logic r_ph;
  logic [1:0] r_pp;
  logic [19:0] r_rpn;
  logic [31:0] cur_ea;
  int bm_cnt, pw_cnt, walk_bad;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (bm_req) begin
        bm_cnt++;
        @(negedge clk);
        bm_rsp_valid = 1'b1; bm_hit = r_bh; bm_raddr = r_braddr; bm_rights = r_brights;
        @(negedge clk);
        bm_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (pw_req) begin
        pw_cnt++;
        if (pw_vsid != seg_m[cur_ea[31:28]][23:0] || pw_page != cur_ea[27:12]) walk_bad++;
        @(negedge clk);
        pw_rsp_valid = 1'b1; pw_hit = r_ph; pw_pp = r_pp; pw_rpn = r_rpn;
        @(negedge clk);
        pw_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic seg_write(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    seg_we = 1'b1; seg_idx = idx; seg_wdata = val;
    @(negedge clk);
    seg_we = 1'b0;
    seg_m[idx] = val;
  endtask

  function automatic logic [2:0] page_rt(input logic key, input logic [1:0] pp, input logic nx);
    logic [2:0] r;
    case ({key, pp})
      3'b011, 3'b101, 3'b111: r = 3'b001;
      3'b100: r = 3'b000;
      default: r = 3'b011;
    endcase
    r[2] = !nx;
    return r;
  endfunction

  task automatic xact(input string tag, input logic [31:0] ea, input logic [1:0] acc, input logic user,
                      input logic it, input logic dt, input logic bh, input logic [31:0] braddr,
                      input logic [2:0] brt, input logic ph, input logic [1:0] pp, input logic [19:0] rpn);
    logic [2:0] need, rr, e_rt;
    logic [31:0] sr, e_ra, e_ic, e_dar, e_ds;
    logic key, e_bm, e_pw;
    logic [1:0] why, e_kind;
    int t;
    r_bh = bh; r_braddr = braddr; r_brights = brt; r_ph = ph; r_pp = pp; r_rpn = rpn;
    cur_ea = ea; bm_cnt = 0; pw_cnt = 0; walk_bad = 0;
    need = (acc == 2) ? 3'b100 : (acc == 1) ? 3'b010 : 3'b001;
    why = 0; e_ra = 0; e_rt = 0; e_bm = 0; e_pw = 0;
    sr = seg_m[ea[31:28]];
    key = user ? sr[29] : sr[30];
    if ((acc == 2 && !it) || (acc != 2 && !dt)) begin
      e_ra = ea; e_rt = 3'b111;
    end else begin
      e_bm = 1;
      if (bh) begin
        if ((need & ~brt) != 0) why = 1; else begin e_ra = braddr; e_rt = brt; end
      end else if (sr[31]) begin
        if (sr[28:20] == 9'h07F) begin e_ra = {sr[3:0], ea[27:0]}; e_rt = 3'b111; end
        else if (acc == 2) why = 3;
        else if ((acc == 0 && !key) || (acc == 1 && key)) begin e_ra = ea; e_rt = 3'b011; end
        else why = 1;
      end else if (acc == 2 && sr[28]) begin
        why = 3;
      end else begin
        e_pw = 1;
        rr = page_rt(key, pp, sr[28]);
        if (!ph) why = 2;
        else if ((need & ~rr) != 0) why = 1;
        else begin e_ra = {rpn, ea[11:0]}; e_rt = rr; end
      end
    end
    e_kind = 0; e_ic = 0; e_dar = 0; e_ds = 0;
    if (why != 0) begin
      if (acc == 2) begin
        e_kind = 1;
        e_ic = (why == 1) ? 32'h0800_0000 : (why == 2) ? 32'h4000_0000 : 32'h1000_0000;
      end else begin
        e_kind = 2; e_dar = ea;
        e_ds = (why == 1) ? ((acc == 1) ? 32'h0A00_0000 : 32'h0800_0000)
                          : ((acc == 1) ? 32'h4200_0000 : 32'h4000_0000);
      end
    end
    @(negedge clk);
    check(req_ready === 1'b1, {tag, " R12 ready before request"}, {31'd0, req_ready}, 32'd1);
    req_ea = ea; req_acc = acc; req_user = user; itrans_en = it; dtrans_en = dt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (done !== 1'b1 && t < 100) begin
      @(negedge clk);
      t++;
    end
    check(done === 1'b1, {tag, " R12 done"}, {31'd0, done}, 32'd1);
    check(raddr === e_ra && rights === e_rt, {tag, " R9 address/rights"}, raddr, e_ra);
    check(fault === (why != 0) && exc_kind === e_kind, {tag, " R12 fault kind"}, {30'd0, exc_kind}, {30'd0, e_kind});
    check(icode === e_ic, {tag, " R10 instr code"}, icode, e_ic);
    check(dar === e_dar && dsisr === e_ds, {tag, " R11 data status"}, dsisr, e_ds);
    check((bm_cnt != 0) == e_bm, {tag, " R2 matcher use"}, bm_cnt, {31'd0, e_bm});
    check((pw_cnt != 0) == e_pw && walk_bad == 0, {tag, " R4 walker use"}, pw_cnt, {31'd0, e_pw});
    @(negedge clk);
    check(done === 1'b0 && raddr === e_ra && dsisr === e_ds, {tag, " R12 held"}, raddr, e_ra);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done === 0 && fault === 0 && raddr === 0 && rights === 0 && exc_kind === 0, "R13 reset outputs", raddr, 0);
    check(icode === 0 && dar === 0 && dsisr === 0 && req_ready === 1, "R13 reset syndromes", dsisr, 0);
    for (int i = 0; i < 16; i++) seg_write(i[3:0], {8'h00, 4'h0, i[3:0], 16'h1234});
    // directed corners
    xact("R1 fetch untranslated", 32'h8000_1ABC, 2, 0, 0, 1, 1, 32'h0, 3'b000, 1, 0, 20'h0);
    xact("R1 store untranslated", 32'h1234_5678, 1, 1, 1, 0, 1, 32'h0, 3'b000, 1, 0, 20'h0);
    xact("R2 block hit load", 32'h3000_0010, 0, 0, 1, 1, 1, 32'hABCD_E000, 3'b101, 1, 0, 20'h0);
    xact("R3 block prot store", 32'h3000_0020, 1, 0, 1, 1, 1, 32'hABCD_E000, 3'b101, 1, 0, 20'h0);
    xact("R3 block prot fetch", 32'h3000_0030, 2, 0, 1, 1, 1, 32'hABCD_E000, 3'b011, 1, 0, 20'h0);
    seg_write(4'h5, 32'h1000_0042);
    xact("R5 noexec fetch", 32'h5000_0100, 2, 0, 1, 1, 0, 0, 0, 1, 0, 20'h11);
    seg_write(4'h6, 32'h87F0_0009);
    xact("R6 forced fetch", 32'h6ABC_DEF0, 2, 0, 1, 1, 0, 0, 0, 1, 0, 20'h0);
    seg_write(4'h7, 32'h8010_0000);
    xact("R6 dstore fetch", 32'h7000_0000, 2, 0, 1, 1, 0, 0, 0, 1, 0, 20'h0);
    xact("R7 dstore load key0", 32'h7000_0044, 0, 0, 1, 1, 0, 0, 0, 1, 0, 20'h0);
    xact("R7 dstore store key0", 32'h7000_0048, 1, 0, 1, 1, 0, 0, 0, 1, 0, 20'h0);
    seg_write(4'h8, 32'h2000_0077);
    xact("R8 user key1 pp0 load", 32'h8000_2000, 0, 1, 1, 1, 0, 0, 0, 1, 0, 20'h55);
    xact("R8 sup key0 pp0 store", 32'h8000_2004, 1, 0, 1, 1, 0, 0, 0, 1, 0, 20'h55);
    xact("R11 pp3 store", 32'h8000_3000, 1, 0, 1, 1, 0, 0, 0, 1, 3, 20'h66);
    xact("R10 miss store", 32'h8000_4000, 1, 0, 1, 1, 0, 0, 0, 0, 0, 20'h0);
    xact("R10 miss fetch", 32'h8000_5000, 2, 0, 1, 1, 0, 0, 0, 0, 0, 20'h0);
    // random mix with fixed seed
    void'($urandom(32'd1357));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ea;
      ea = $urandom;
      if ($urandom % 6 == 0) begin
        case ($urandom % 3)
          0: v = {1'b0, 3'($urandom), 4'h0, 24'($urandom)};
          1: v = {1'b1, 2'($urandom), 9'h07F, 16'($urandom), 4'($urandom)};
          default: v = {1'b1, 2'($urandom), 9'($urandom | 32'h100), 20'($urandom)};
        endcase
        seg_write(ea[31:28], v);
      end
      xact("RND", ea, 2'($urandom % 3), 1'($urandom), ($urandom % 8) != 0, ($urandom % 8) != 0,
           ($urandom % 3) == 0, $urandom, 3'($urandom), ($urandom % 4) != 0, 2'($urandom), 20'($urandom));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule